// File: doc/BRIEF.md
# Host Configuration Register Bank

A bank of 8-bit registers that a host processor reaches over a plain synchronous bus. The bus has a 5-bit address, write data, read data, a write enable and a read enable. The bank holds three kinds of register:

- control registers, including a first control register whose bits drive three level requests to the rest of the chip: global set/reset, readback request and reconfiguration request;
- a general-purpose control register and a scratchpad;
- views onto outside logic: a status byte, a port for configuration data, a 16-bit readback address and a read-only 32-bit device identifier.

The upper half of the address space, 0x10 to 0x1F, is not decoded in the bank. Accesses there are handed to user logic through a select strobe and a 4-bit offset, and user logic supplies the read data.

Writes take effect at the clock edge that ends the access cycle. A read loads a registered read-data output at that same edge. The read-data output then holds its value until the next read. The requests that leave the bank never feed back into it. Global set/reset and reconfiguration therefore leave every register in the bank untouched, and the host can always deassert them again.

Top module: `host_cfg_bank`

## Requirements
- R1: After reset: gsrOut=0, readbackReqN=1, reconfigReqN=1, busRdData=0x00. Control 1 (0x00) reads 0xA0. Control 2 (0x01), scratchpad (0x02) and readback address (0x05, 0x06) read 0x00.
- R2: Control 1 at 0x00 stores bits 0, 5 and 7 of a write. A read returns those bits in the same positions. Bits 1–4 and 6 always read 0.
- R3: gsrOut (active high) follows control 1 bit 0 from the edge of the write onward. It stays at that level until control 1 is written again.
- R4: readbackReqN follows control 1 bit 5 and reconfigReqN follows control 1 bit 7. Both requests are asserted when low, and each holds its level until control 1 is rewritten.
- R5: While gsrOut=1 and reconfigReqN=0, every register at 0x00–0x0F keeps its value unless the host writes it. Writes and reads behave normally during that time.
- R6: Control 2 (0x01, driven on ctrl2Out) and the scratchpad (0x02) are full 8-bit read/write registers.
- R7: The readback address is written as a low byte at 0x05 and a high byte at 0x06. It drives readbackAddr as {high, low} and reads back at the same addresses.
- R8: Addresses 0x07, 0x08, 0x09 and 0x0A read bits [7:0], [15:8], [23:16] and [31:24] of the DEVICE_ID parameter. Writes to these addresses have no effect.
- R9: Address 0x03 reads statusIn as sampled at the read edge. Writes to 0x03 change nothing.
- R10: An access to 0x04 drives the configuration data port. A write raises cfgWrStb in the access cycle, with cfgWrData equal to busWrData. A read raises cfgRdStb in the access cycle and returns cfgRdData.
- R11: Addresses 0x0B–0x0F read 0x00. Writes to them change no register, no output level and no later read.
- R12: An access to 0x10–0x1F raises userSel combinationally for that cycle only. userAddr carries address bits [3:0] and userWr is 1 for a write. A read returns userRdData. No local register changes.
- R13: busRdData changes only at the edge that ends a read cycle, and holds otherwise. A read and a write to the same address in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 5 | Host address |
| busWrData | input | 8 | Host write data |
| busWrEn | input | 1 | Host write enable for this cycle |
| busRdEn | input | 1 | Host read enable for this cycle |
| busRdData | output | 8 | Registered read data |
| gsrOut | output | 1 | Global set/reset level, active high |
| readbackReqN | output | 1 | Readback request, active low |
| reconfigReqN | output | 1 | Reconfiguration request, active low |
| ctrl2Out | output | 8 | Contents of control register 2 |
| readbackAddr | output | 16 | Readback address {high, low} |
| statusIn | input | 8 | Status byte shown at 0x03 |
| cfgWrStb | output | 1 | Configuration data write strobe |
| cfgRdStb | output | 1 | Configuration data read strobe |
| cfgWrData | output | 8 | Configuration data to the engine |
| cfgRdData | input | 8 | Configuration data from the engine |
| userSel | output | 1 | User window access strobe |
| userWr | output | 1 | User window access is a write |
| userAddr | output | 4 | Offset within the user window |
| userWrData | output | 8 | Write data to user logic |
| userRdData | input | 8 | Read data from user logic |

## Verification
The bench drives global set/reset and reconfiguration together and then rewrites and reads every writable register. A design that let either request clear its own bank would lose the scratchpad, control 2 or the readback address, or could never deassert the request. It writes all ones to control 1 to expose reserved bits that are stored or read back as ones, and writes into the identifier, status and reserved addresses to catch decoders that alias them onto real registers. It walks both ends of the user window to catch a local register being changed by a forwarded access, and a select strobe that lasts more than one cycle. It issues a read and a write to the scratchpad in the same cycle to catch a read path that returns the new value instead of the old one.

// File: rtl/host_cfg_pkg.sv
package host_cfg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int WIN_W  = 4;
  localparam int ID_W   = 32;
  localparam int ID_BYTES = ID_W / DATA_W;
  localparam int ID_SEL_W = $clog2(ID_BYTES);
  localparam int RBA_W  = 2 * DATA_W;

  localparam int GSR_BIT = 0;
  localparam int RB_BIT  = 5;
  localparam int RC_BIT  = 7;

  typedef enum logic [3:0] {
    SRC_ZERO, SRC_CTRL1, SRC_CTRL2, SRC_SCRATCH, SRC_STATUS,
    SRC_CFG, SRC_RBLO, SRC_RBHI, SRC_ID, SRC_USER
  } rdSrc_e;

  typedef struct packed {
    logic                wrCtrl1;
    logic                wrCtrl2;
    logic                wrScratch;
    logic                wrRbLo;
    logic                wrRbHi;
    logic                rdLoad;
    rdSrc_e              rdSrc;
    logic [ID_SEL_W-1:0] idSel;
  } bankStb_t;
endpackage

// File: rtl/host_cfg_ctrl.sv
module host_cfg_ctrl
  import host_cfg_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output bankStb_t          stb,
  output logic              cfgWrStb,
  output logic              cfgRdStb,
  output logic              userSel,
  output logic              userWr,
  output logic [WIN_W-1:0]  userAddr
);
  logic [WIN_W-1:0] offset;
  logic             inWindow;

  assign offset   = busAddr[WIN_W-1:0];
  assign inWindow = busAddr[ADDR_W-1];
  assign userAddr = offset;

  always_comb begin
    stb        = '0;
    stb.rdSrc  = SRC_ZERO;
    stb.rdLoad = busRdEn;
    cfgWrStb   = 1'b0;
    cfgRdStb   = 1'b0;
    userSel    = 1'b0;
    userWr     = 1'b0;
    if (inWindow) begin
      userSel   = busWrEn | busRdEn;
      userWr    = busWrEn;
      stb.rdSrc = SRC_USER;
    end else begin
      case (offset)
        4'h0: begin stb.wrCtrl1   = busWrEn; stb.rdSrc = SRC_CTRL1;   end
        4'h1: begin stb.wrCtrl2   = busWrEn; stb.rdSrc = SRC_CTRL2;   end
        4'h2: begin stb.wrScratch = busWrEn; stb.rdSrc = SRC_SCRATCH; end
        4'h3: stb.rdSrc = SRC_STATUS;
        4'h4: begin
          cfgWrStb  = busWrEn;
          cfgRdStb  = busRdEn;
          stb.rdSrc = SRC_CFG;
        end
        4'h5: begin stb.wrRbLo = busWrEn; stb.rdSrc = SRC_RBLO; end
        4'h6: begin stb.wrRbHi = busWrEn; stb.rdSrc = SRC_RBHI; end
        4'h7: begin stb.rdSrc = SRC_ID; stb.idSel = ID_SEL_W'(0); end
        4'h8: begin stb.rdSrc = SRC_ID; stb.idSel = ID_SEL_W'(1); end
        4'h9: begin stb.rdSrc = SRC_ID; stb.idSel = ID_SEL_W'(2); end
        4'hA: begin stb.rdSrc = SRC_ID; stb.idSel = ID_SEL_W'(3); end
        default: stb.rdSrc = SRC_ZERO;
      endcase
    end
  end
endmodule

// File: rtl/host_cfg_dp.sv
module host_cfg_dp
  import host_cfg_pkg::*;
#(
  parameter logic [ID_W-1:0] DEVICE_ID = 32'h5A3C_96E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStb_t          stb,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] cfgRdData,
  input  logic [DATA_W-1:0] userRdData,
  output logic [DATA_W-1:0] busRdData,
  output logic              gsrOut,
  output logic              readbackReqN,
  output logic              reconfigReqN,
  output logic [DATA_W-1:0] ctrl2Out,
  output logic [RBA_W-1:0]  readbackAddr
);
  logic [DATA_W-1:0] scratch;
  logic [DATA_W-1:0] rbLo;
  logic [DATA_W-1:0] rbHi;
  logic [DATA_W-1:0] ctrl1View;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] idByte [ID_BYTES];

  for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
    assign idByte[i] = DEVICE_ID[i*DATA_W +: DATA_W];
  end

  // Request levels: no path from them back into this bank.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gsrOut       <= 1'b0;
      readbackReqN <= 1'b1;
      reconfigReqN <= 1'b1;
    end else if (stb.wrCtrl1) begin
      gsrOut       <= busWrData[GSR_BIT];
      readbackReqN <= busWrData[RB_BIT];
      reconfigReqN <= busWrData[RC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrl2Out <= '0;
      scratch  <= '0;
      rbLo     <= '0;
      rbHi     <= '0;
    end else begin
      if (stb.wrCtrl2)   ctrl2Out <= busWrData;
      if (stb.wrScratch) scratch  <= busWrData;
      if (stb.wrRbLo)    rbLo     <= busWrData;
      if (stb.wrRbHi)    rbHi     <= busWrData;
    end
  end

  assign readbackAddr = {rbHi, rbLo};

  always_comb begin
    ctrl1View          = '0;
    ctrl1View[GSR_BIT] = gsrOut;
    ctrl1View[RB_BIT]  = readbackReqN;
    ctrl1View[RC_BIT]  = reconfigReqN;
  end

  always_comb begin
    case (stb.rdSrc)
      SRC_CTRL1:   rdMux = ctrl1View;
      SRC_CTRL2:   rdMux = ctrl2Out;
      SRC_SCRATCH: rdMux = scratch;
      SRC_STATUS:  rdMux = statusIn;
      SRC_CFG:     rdMux = cfgRdData;
      SRC_RBLO:    rdMux = rbLo;
      SRC_RBHI:    rdMux = rbHi;
      SRC_ID:      rdMux = idByte[stb.idSel];
      SRC_USER:    rdMux = userRdData;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           busRdData <= '0;
    else if (stb.rdLoad) busRdData <= rdMux;
  end
endmodule

// File: rtl/host_cfg_bank.sv
module host_cfg_bank
  import host_cfg_pkg::*;
#(
  parameter logic [ID_W-1:0] DEVICE_ID = 32'h5A3C_96E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic              gsrOut,
  output logic              readbackReqN,
  output logic              reconfigReqN,
  output logic [DATA_W-1:0] ctrl2Out,
  output logic [RBA_W-1:0]  readbackAddr,
  input  logic [DATA_W-1:0] statusIn,
  output logic              cfgWrStb,
  output logic              cfgRdStb,
  output logic [DATA_W-1:0] cfgWrData,
  input  logic [DATA_W-1:0] cfgRdData,
  output logic              userSel,
  output logic              userWr,
  output logic [WIN_W-1:0]  userAddr,
  output logic [DATA_W-1:0] userWrData,
  input  logic [DATA_W-1:0] userRdData
);
  bankStb_t stb;

  assign cfgWrData  = busWrData;
  assign userWrData = busWrData;

  host_cfg_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .stb     (stb),
    .cfgWrStb(cfgWrStb),
    .cfgRdStb(cfgRdStb),
    .userSel (userSel),
    .userWr  (userWr),
    .userAddr(userAddr)
  );

  host_cfg_dp #(.DEVICE_ID(DEVICE_ID)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .busWrData   (busWrData),
    .statusIn    (statusIn),
    .cfgRdData   (cfgRdData),
    .userRdData  (userRdData),
    .busRdData   (busRdData),
    .gsrOut      (gsrOut),
    .readbackReqN(readbackReqN),
    .reconfigReqN(reconfigReqN),
    .ctrl2Out    (ctrl2Out),
    .readbackAddr(readbackAddr)
  );
endmodule

// File: rtl/host_cfg_chk.sv
module host_cfg_chk
  import host_cfg_pkg::*;
#(
  parameter logic [ID_W-1:0] DEVICE_ID = 32'h5A3C_96E1
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWrData,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdData,
  input logic              gsrOut,
  input logic              readbackReqN,
  input logic              reconfigReqN,
  input logic [RBA_W-1:0]  readbackAddr,
  input logic [DATA_W-1:0] cfgRdData,
  input logic [DATA_W-1:0] userRdData
);
  p_ctrl1_levels_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 5'h00) |=>
      (gsrOut == $past(busWrData[0]) && readbackReqN == $past(busWrData[5])
       && reconfigReqN == $past(busWrData[7])));

  p_level_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && busAddr == 5'h00) |=>
      ($stable(gsrOut) && $stable(readbackReqN) && $stable(reconfigReqN)));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busWrEn |=> $stable(readbackAddr));

  p_rb_lo_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 5'h05) |=> readbackAddr[7:0] == $past(busWrData));

  p_id_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 5'h07) |=> busRdData == DEVICE_ID[7:0]);

  p_cfg_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 5'h04) |=> busRdData == $past(cfgRdData));

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr >= 5'h0B && busAddr <= 5'h0F) |=> busRdData == 8'h00);

  p_user_read_r12: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[4]) |=> busRdData == $past(userRdData));

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdData));
endmodule

bind host_cfg_bank host_cfg_chk #(.DEVICE_ID(DEVICE_ID)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
  .gsrOut(gsrOut), .readbackReqN(readbackReqN), .reconfigReqN(reconfigReqN),
  .readbackAddr(readbackAddr), .cfgRdData(cfgRdData), .userRdData(userRdData)
);

// File: tb/sim_host_cfg_bank.sv
`timescale 1ns/1ps
module sim_host_cfg_bank;
  localparam logic [31:0] TB_ID = 32'hC3D2_E1F0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busRdData, ctrl2Out, cfgWrData, userWrData;
  logic gsrOut, readbackReqN, reconfigReqN, cfgWrStb, cfgRdStb, userSel, userWr;
  logic [15:0] readbackAddr;
  logic [3:0] userAddr;
  logic [7:0] statusIn = 8'h3C, cfgRdData = 8'h96, userRdData = 8'h5A;

  int compared = 0, mismatched = 0;

  // behavioural reference state
  bit m_gsr = 0, m_rb = 1, m_rc = 1;
  logic [7:0] m_c2 = 0, m_sp = 0, m_lo = 0, m_hi = 0, m_rd = 0;

  always #2 clk = ~clk;

  host_cfg_bank #(.DEVICE_ID(TB_ID)) u0 (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                     input string req, input string what);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] modelRead(input logic [4:0] a);
    if (a[4]) return userRdData;
    case (a)
      5'h00: return {m_rc, 1'b0, m_rb, 4'b0, m_gsr};
      5'h01: return m_c2;
      5'h02: return m_sp;
      5'h03: return statusIn;
      5'h04: return cfgRdData;
      5'h05: return m_lo;
      5'h06: return m_hi;
      5'h07, 5'h08, 5'h09, 5'h0A: return 8'((TB_ID >> (8 * (int'(a) - 7))) & 32'hFF);
      default: return 8'h00;
    endcase
  endfunction

  task automatic compareAll(input string req);
    chk(busRdData, m_rd, req, "busRdData");
    chk(gsrOut, m_gsr, req, "gsrOut");
    chk(readbackReqN, m_rb, req, "readbackReqN");
    chk(reconfigReqN, m_rc, req, "reconfigReqN");
    chk(ctrl2Out, m_c2, req, "ctrl2Out");
    chk(readbackAddr, {m_hi, m_lo}, req, "readbackAddr");
  endtask

  // one bus cycle: drive at negedge, check strobes, update model at edge, compare after it
  task automatic cyc(input bit wr, input bit rd, input logic [4:0] a,
                     input logic [7:0] d, input string req);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    #1;
    chk(userSel, (wr | rd) & a[4], req, "userSel");
    if ((wr | rd) && a[4]) begin
      chk(userAddr, a[3:0], req, "userAddr");
      chk(userWr, wr, req, "userWr");
      if (wr) chk(userWrData, d, req, "userWrData");
    end
    chk(cfgWrStb, wr && a == 5'h04, req, "cfgWrStb");
    chk(cfgRdStb, rd && a == 5'h04, req, "cfgRdStb");
    if (wr && a == 5'h04) chk(cfgWrData, d, req, "cfgWrData");
    if (rd) m_rd = modelRead(a);
    if (wr && !a[4]) begin
      case (a)
        5'h00: begin m_gsr = d[0]; m_rb = d[5]; m_rc = d[7]; end
        5'h01: m_c2 = d;
        5'h02: m_sp = d;
        5'h05: m_lo = d;
        5'h06: m_hi = d;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    compareAll(req);
    @(negedge clk);
    busWrEn = 0; busRdEn = 0;
  endtask

  task automatic wrR(input logic [4:0] a, input logic [7:0] d, input string req);
    cyc(1, 0, a, d, req);
  endtask
  task automatic rdR(input logic [4:0] a, input string req);
    cyc(0, 1, a, 8'h00, req);
  endtask
  task automatic idle(input string req);
    cyc(0, 0, 5'h00, 8'h00, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;
    idle("R1");
    rdR(5'h00, "R1"); rdR(5'h01, "R1"); rdR(5'h02, "R1");
    rdR(5'h05, "R1"); rdR(5'h06, "R1");

    wrR(5'h00, 8'hFF, "R2"); rdR(5'h00, "R2");
    idle("R3"); idle("R3");
    wrR(5'h00, 8'h00, "R4"); rdR(5'h00, "R4");
    wrR(5'h00, 8'h21, "R4"); rdR(5'h00, "R2");
    wrR(5'h00, 8'h5F, "R4"); rdR(5'h00, "R2");

    wrR(5'h00, 8'h01, "R5");
    wrR(5'h01, 8'hA5, "R6"); wrR(5'h02, 8'h3C, "R6");
    wrR(5'h05, 8'h12, "R7"); wrR(5'h06, 8'hEF, "R7");
    repeat (4) idle("R5");
    rdR(5'h01, "R5"); rdR(5'h02, "R5"); rdR(5'h05, "R5"); rdR(5'h06, "R5");
    wrR(5'h02, 8'hC3, "R6"); rdR(5'h02, "R6");
    wrR(5'h00, 8'hA0, "R3"); rdR(5'h01, "R5"); rdR(5'h00, "R3");

    for (int i = 7; i <= 10; i++) rdR(5'(i), "R8");
    for (int i = 7; i <= 10; i++) wrR(5'(i), 8'h00, "R8");
    for (int i = 7; i <= 10; i++) rdR(5'(i), "R8");

    statusIn = 8'h81; rdR(5'h03, "R9");
    wrR(5'h03, 8'hFF, "R9");
    statusIn = 8'h7E; rdR(5'h03, "R9");

    wrR(5'h04, 8'h6D, "R10");
    cfgRdData = 8'hB2; rdR(5'h04, "R10");
    cfgRdData = 8'h4B; rdR(5'h04, "R10");

    for (int i = 11; i <= 15; i++) wrR(5'(i), 8'hFF, "R11");
    for (int i = 11; i <= 15; i++) rdR(5'(i), "R11");
    rdR(5'h00, "R11"); rdR(5'h02, "R11"); rdR(5'h05, "R11");

    userRdData = 8'h11; rdR(5'h10, "R12");
    wrR(5'h10, 8'h99, "R12");
    userRdData = 8'hEE; rdR(5'h1F, "R12");
    wrR(5'h1F, 8'h77, "R12"); idle("R12");
    rdR(5'h00, "R12"); rdR(5'h01, "R12"); rdR(5'h02, "R12");

    cyc(1, 1, 5'h02, 8'h5A, "R13");
    idle("R13"); idle("R13");
    rdR(5'h02, "R13");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule